// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a circular ring of transmit descriptors kept in a shared 128 KB SRAM and turns the buffers they point to into a byte stream. Software fills descriptors and hands them over by setting an ownership bit. It then either raises a demand request or waits for the periodic poll tick. When the transmitter is enabled, the engine walks forward from its current ring index. For each usable descriptor it streams the buffer's bytes, returns the descriptor by clearing ownership, and advances.

Frames may span several descriptors. A start flag opens a frame and an end flag closes it. The stream carries a first marker on the opening byte and a last marker on the closing byte, so that the sink sees a chain as one frame. A walk ends at the first descriptor that is not handed over. It also ends on a malformed entry, with an error pulse, or after a full lap of the ring, with a warning pulse.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the stream is idle, the SRAM port is quiet, and the first walk begins at ring index 0.
- R2: A walk starts only while idle with `tx_on` high and `demand` or `poll_tick` high. `tdmd_clr` pulses for one cycle at that start and SRAM fetching begins on the next cycle. With `tx_on` low, a demand request causes no SRAM access.
- R3: Descriptor i occupies four 16-bit little-endian words at `ring_base + 8*i`. The buffer byte address is word0 plus word1[7:0] shifted left by 16. In word1, bit 15 is ownership, bit 9 is frame start and bit 8 is frame end. The byte count is 4096 minus word2[11:0].
- R4: A descriptor that is not owned, or whose word2[15:12] differs from 4'b1111, ends the walk with no SRAM write and no streamed byte.
- R5: A byte count below 12 or above 1900 pulses `err_len` and ends the walk with no write. Counts of exactly 12 and 1900 are accepted.
- R6: A descriptor without frame start while no frame is open pulses `err_chain` and ends the walk with no write.
- R7: A descriptor with frame start while a frame is open pulses `out_drop`, and a new frame begins with that descriptor.
- R8: Buffer bytes are streamed in address order. `out_first` marks the first byte of a frame-start buffer and `out_last` marks the final byte of a frame-end buffer. A chain across descriptors forms one frame.
- R9: While `out_valid` is high and `out_ready` is low, the data and both markers stay unchanged.
- R10: After its bytes are sent, a descriptor gets word1 rewritten with bit 15 cleared and words 2 and 3 rewritten unchanged. `tint` pulses with the last write of a frame-end descriptor.
- R11: The index advances by one modulo 2^`ring_log2` after each completed descriptor. Coming back to the index where the walk started pulses `ring_full` and ends the walk.
- R12: Buffer byte addresses wrap modulo the SRAM size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_on | input | 1 | Transmitter enable |
| demand | input | 1 | Software request for an immediate walk |
| poll_tick | input | 1 | Periodic walk request |
| ring_base | input | AW | Byte address of descriptor 0, word aligned |
| ring_log2 | input | 3 | Ring holds 2^ring_log2 descriptors |
| mem_req | output | 1 | SRAM access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | SRAM byte address, bit 0 zero |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 16 | Read word, valid one cycle after a read request |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Stream byte |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Last byte of a frame |
| out_drop | output | 1 | Open partial frame is discarded |
| tint | output | 1 | Frame transmitted |
| tdmd_clr | output | 1 | Demand request consumed |
| err_len | output | 1 | Byte count out of range |
| err_chain | output | 1 | Continuation descriptor with no open frame |
| ring_full | output | 1 | Walk lapped the whole ring |

## Verification
The walk is exercised on several ring contents. One ring holds a single-buffer frame at an odd address, which exposes byte-lane selection. Another holds a three-descriptor chain under random backpressure, which separates frame-level markers from per-buffer ones. A third places a buffer across the top of the SRAM, which tests address wrapping. Error and early-stop cases use length boundaries on both sides, a bad marker nibble, a continuation with no open frame, and a restarted frame. In each case the bench looks at the SRAM afterwards to confirm that the descriptor was left untouched. A two-entry ring that is fully handed over separates the lap warning from an ordinary stop, and a second walk over the same ring confirms that returned descriptors are skipped.

// File: rtl/tx_ring_engine.sv
module tx_ring_engine #(
  parameter int AW      = 17,
  parameter int LOGW    = 3,
  parameter int MIN_LEN = 12,
  parameter int MAX_LEN = 1900
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_on,
  input  logic          demand,
  input  logic          poll_tick,
  input  logic [AW-1:0] ring_base,
  input  logic [LOGW-1:0] ring_log2,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_first,
  output logic          out_last,
  output logic          out_drop,
  output logic          tint,
  output logic          tdmd_clr,
  output logic          err_len,
  output logic          err_chain,
  output logic          ring_full
);
  localparam int IW = (1 << LOGW) - 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_RDB, S_CAP, S_OUT, S_WB} st_t;
  st_t st;

  logic [IW-1:0] idx, start_idx;
  logic [2:0]    fcnt;
  logic [1:0]    wcnt;
  logic [15:0]   dw0, dw1, dw2, dw3;
  logic          open_q, first_q;
  logic [AW-1:0] ptr;
  logic [12:0]   remain;
  logic [7:0]    byte_q;

  wire [IW-1:0] mask    = IW'(({{IW{1'b0}}, 1'b1} << ring_log2) - 1);
  wire [IW-1:0] idx_nxt = (idx + 1'b1) & mask;
  wire [AW-1:0] dbase   = ring_base + AW'({idx, 3'b000});

  wire        own    = dw1[15];
  wire        stp    = dw1[9];
  wire        enp    = dw1[8];
  wire        usable = own && (dw2[15:12] == 4'hF);
  wire [12:0] cnt    = 13'h1000 - {1'b0, dw2[11:0]};
  wire        len_ok = (cnt >= 13'(MIN_LEN)) && (cnt <= 13'(MAX_LEN));
  wire        in_chk = (st == S_CHECK);
  wire        wb_end = (st == S_WB) && (wcnt == 2'd2);

  assign tdmd_clr  = (st == S_IDLE) && tx_on && (demand || poll_tick);
  assign err_len   = in_chk && usable && !len_ok;
  assign err_chain = in_chk && usable && len_ok && !stp && !open_q;
  assign out_drop  = in_chk && usable && len_ok && stp && open_q;
  assign tint      = wb_end && enp;
  assign ring_full = wb_end && (idx_nxt == start_idx);

  assign out_valid = (st == S_OUT);
  assign out_data  = byte_q;
  assign out_first = out_valid && first_q;
  assign out_last  = out_valid && enp && (remain == 13'd1);

  assign mem_req = ((st == S_FETCH) && (fcnt != 3'd4)) || (st == S_RDB) || (st == S_WB);
  assign mem_we  = (st == S_WB);

  always_comb begin
    case (st)
      S_FETCH: mem_addr = dbase + AW'({fcnt[1:0], 1'b0});
      S_RDB:   mem_addr = {ptr[AW-1:1], 1'b0};
      S_WB:    mem_addr = dbase + AW'({2'(wcnt + 2'd1), 1'b0});
      default: mem_addr = '0;
    endcase
    case (wcnt)
      2'd0:    mem_wdata = {1'b0, dw1[14:0]};
      2'd1:    mem_wdata = dw2;
      default: mem_wdata = dw3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      start_idx <= '0;
      fcnt      <= '0;
      wcnt      <= '0;
      dw0       <= '0;
      dw1       <= '0;
      dw2       <= '0;
      dw3       <= '0;
      open_q    <= 1'b0;
      first_q   <= 1'b0;
      ptr       <= '0;
      remain    <= '0;
      byte_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (tdmd_clr) begin
          start_idx <= idx;
          fcnt      <= '0;
          st        <= S_FETCH;
        end
        S_FETCH: begin
          case (fcnt)
            3'd1:    dw0 <= mem_rdata;
            3'd2:    dw1 <= mem_rdata;
            3'd3:    dw2 <= mem_rdata;
            3'd4:    dw3 <= mem_rdata;
            default: ;
          endcase
          if (fcnt == 3'd4) st <= S_CHECK;
          else fcnt <= fcnt + 3'd1;
        end
        S_CHECK: begin
          if (!usable || !len_ok || (!stp && !open_q)) begin
            st <= S_IDLE;
          end else begin
            open_q  <= 1'b1;
            first_q <= stp;
            ptr     <= AW'({dw1[7:0], dw0});
            remain  <= cnt;
            st      <= S_RDB;
          end
        end
        S_RDB: st <= S_CAP;
        S_CAP: begin
          byte_q <= ptr[0] ? mem_rdata[15:8] : mem_rdata[7:0];
          st     <= S_OUT;
        end
        S_OUT: if (out_ready) begin
          first_q <= 1'b0;
          if (remain == 13'd1) begin
            wcnt <= '0;
            st   <= S_WB;
          end else begin
            ptr    <= ptr + 1'b1;
            remain <= remain - 13'd1;
            st     <= S_RDB;
          end
        end
        S_WB: begin
          if (wcnt == 2'd2) begin
            if (enp) open_q <= 1'b0;
            idx <= idx_nxt;
            fcnt <= '0;
            st <= (idx_nxt == start_idx) ? S_IDLE : S_FETCH;
          end else begin
            wcnt <= wcnt + 2'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_ring_engine_chk.sv
module tx_ring_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_first,
  input logic       out_last,
  input logic       mem_req,
  input logic       mem_we,
  input logic       tint,
  input logic       tdmd_clr,
  input logic       err_len,
  input logic       err_chain
);
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last));

  assert_fetch_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tdmd_clr |=> mem_req && !mem_we);

  assert_write_not_streaming_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req && !out_valid);

  assert_tint_with_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tint |-> mem_we);

  assert_error_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_len || err_chain |=> !mem_req && !out_valid);

  assert_exclusive_events_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_len, err_chain, tdmd_clr, mem_we}));
endmodule

bind tx_ring_engine tx_ring_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_first(out_first), .out_last(out_last),
  .mem_req(mem_req), .mem_we(mem_we), .tint(tint), .tdmd_clr(tdmd_clr),
  .err_len(err_len), .err_chain(err_chain)
);

// File: tb/tx_ring_engine_tb_top.sv
module tx_ring_engine_tb_top;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_on = 1'b0, demand = 1'b0, poll_tick = 1'b0;
  logic [AW-1:0] ring_base = 17'h1000;
  logic [2:0] ring_log2 = 3'd3;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic out_valid, out_ready, out_first, out_last, out_drop;
  logic [7:0] out_data;
  logic tint, tdmd_clr, err_len, err_chain, ring_full;

  always #5 clk = ~clk;

  tx_ring_engine dut_i (
    .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .demand(demand), .poll_tick(poll_tick),
    .ring_base(ring_base), .ring_log2(ring_log2),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .out_drop(out_drop),
    .tint(tint), .tdmd_clr(tdmd_clr), .err_len(err_len), .err_chain(err_chain),
    .ring_full(ring_full)
  );

  logic [15:0] mem [0:65535];
  logic tb_we = 1'b0;
  logic [15:0] tb_a = '0, tb_d = '0;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[AW-1:1]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[AW-1:1]];
    end
    if (tb_we) mem[tb_a] <= tb_d;
  end

  int n_chk = 0, n_fail = 0;
  int c_tint = 0, c_tdmd = 0, c_elen = 0, c_echain = 0, c_drop = 0, c_full = 0, c_req = 0;
  logic [9:0] expq [$];
  bit bp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit hold_prev = 1'b0;
  logic [9:0] held;
  bit done = 1'b0;
  string cur_req = "R8";

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp ? lfsr[0] : 1'b1;
    if (rst_n) begin
      if (tint) c_tint++;
      if (tdmd_clr) c_tdmd++;
      if (err_len) c_elen++;
      if (err_chain) c_echain++;
      if (out_drop) c_drop++;
      if (ring_full) c_full++;
      if (mem_req) c_req++;
      if (hold_prev) chk("R9 hold", {out_valid, out_first, out_last, out_data}, {1'b1, held});
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk({cur_req, " unexpected byte"}, {out_first, out_last, out_data}, 0);
        else chk({cur_req, " byte"}, {out_first, out_last, out_data}, expq.pop_front());
      end
      hold_prev = out_valid && !out_ready;
      held = {out_first, out_last, out_data};
    end
  end

  function automatic logic [7:0] rb(input int a);
    logic [15:0] w = mem[(a >> 1) & 16'hFFFF];
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  task automatic mem_wr(input int a, input logic [15:0] d);
    tb_a = 16'(a); tb_d = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic fill_buf(input int a, input int n);
    for (int w = a >> 1; w <= (a + n - 1) >> 1; w++)
      mem_wr(w & 16'hFFFF, {8'(w * 29 + 7), 8'(w * 11 + 90)});
  endtask

  task automatic push_buf(input int a, input int n, input bit f, input bit l);
    for (int i = 0; i < n; i++)
      expq.push_back({(i == 0) && f, (i == n - 1) && l, rb(a + i)});
  endtask

  function automatic int dword(input int base, input int i, input int k);
    return ((base + 8 * i) >> 1) + k;
  endfunction

  task automatic put_desc(input int base, input int i, input int addr, input bit own,
                          input bit stp, input bit enp, input int cnt, input logic [3:0] mark,
                          input logic [15:0] w3);
    mem_wr(dword(base, i, 0), addr[15:0]);
    mem_wr(dword(base, i, 1), {own, 5'b0, stp, enp, addr[23:16]});
    mem_wr(dword(base, i, 2), {mark, 12'(4096 - cnt)});
    mem_wr(dword(base, i, 3), w3);
  endtask

  task automatic clear_counts;
    c_tint = 0; c_tdmd = 0; c_elen = 0; c_echain = 0; c_drop = 0; c_full = 0; c_req = 0;
  endtask

  task automatic scan(input bit use_poll);
    int q = 0;
    if (use_poll) poll_tick = 1'b1; else demand = 1'b1;
    @(negedge clk);
    poll_tick = 1'b0; demand = 1'b0;
    while (q < 8) begin
      @(negedge clk);
      if (!mem_req && !out_valid) q++; else q = 0;
    end
  endtask

  initial begin
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 mem_req", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tdmd_clr idle", tdmd_clr, 0);

    // R2: demand ignored with transmitter off
    clear_counts();
    scan(1'b0);
    chk("R2 no access when off", c_req, 0);
    chk("R2 no tdmd_clr when off", c_tdmd, 0);
    tx_on = 1'b1;

    // R3 R8 R10: single buffer at odd address, first walk from index 0
    cur_req = "R3";
    put_desc(32'h1000, 0, 32'h2001, 1, 1, 1, 20, 4'hF, 16'h0BEE);
    put_desc(32'h1000, 1, 0, 0, 0, 0, 20, 4'hF, 16'h0000);
    fill_buf(32'h2001, 20);
    push_buf(32'h2001, 20, 1, 1);
    clear_counts();
    scan(1'b0);
    chk("R8 all bytes sent", expq.size(), 0);
    chk("R2 tdmd_clr once", c_tdmd, 1);
    chk("R10 tint", c_tint, 1);
    chk("R10 word1 own cleared", mem[dword(32'h1000, 0, 1)], 16'h0300);
    chk("R10 word2 kept", mem[dword(32'h1000, 0, 2)], 16'hFFEC);
    chk("R10 word3 kept", mem[dword(32'h1000, 0, 3)], 16'h0BEE);

    // R8 R9: chain of three with backpressure, min length 12
    cur_req = "R8";
    bp = 1'b1;
    put_desc(32'h1000, 1, 32'h4000, 1, 1, 0, 12, 4'hF, 16'h0000);
    put_desc(32'h1000, 2, 32'h4100, 1, 0, 0, 15, 4'hF, 16'h1234);
    put_desc(32'h1000, 3, 32'h4203, 1, 0, 1, 13, 4'hF, 16'h0000);
    put_desc(32'h1000, 4, 0, 0, 0, 0, 12, 4'hF, 16'h0000);
    fill_buf(32'h4000, 12); fill_buf(32'h4100, 15); fill_buf(32'h4203, 13);
    push_buf(32'h4000, 12, 1, 0); push_buf(32'h4100, 15, 0, 0); push_buf(32'h4203, 13, 0, 1);
    clear_counts();
    scan(1'b0);
    bp = 1'b0;
    chk("R8 chain all bytes", expq.size(), 0);
    chk("R10 one tint for chain", c_tint, 1);
    chk("R7 no drop in chain", c_drop, 0);
    chk("R10 middle word1", mem[dword(32'h1000, 2, 1)], 16'h0000);
    chk("R10 middle word3", mem[dword(32'h1000, 2, 3)], 16'h1234);
    chk("R10 end word1", mem[dword(32'h1000, 3, 1)], 16'h0100);

    // R5: length bounds
    cur_req = "R5";
    put_desc(32'h1000, 4, 32'h5000, 1, 1, 1, 1901, 4'hF, 16'h0000);
    clear_counts();
    scan(1'b0);
    chk("R5 err_len above max", c_elen, 1);
    chk("R5 untouched above max", mem[dword(32'h1000, 4, 1)], 16'h8300);
    put_desc(32'h1000, 4, 32'h5000, 1, 1, 1, 11, 4'hF, 16'h0000);
    clear_counts();
    scan(1'b0);
    chk("R5 err_len below min", c_elen, 1);
    chk("R5 no tint on error", c_tint, 0);
    put_desc(32'h1000, 4, 32'h5000, 1, 1, 1, 1900, 4'hF, 16'h0000);
    put_desc(32'h1000, 5, 0, 0, 0, 0, 12, 4'hF, 16'h0000);
    fill_buf(32'h5000, 1900);
    push_buf(32'h5000, 1900, 1, 1);
    clear_counts();
    scan(1'b0);
    chk("R5 max length accepted", expq.size(), 0);
    chk("R5 no err at max", c_elen, 0);
    chk("R5 tint at max", c_tint, 1);

    // R4: bad marker nibble stops walk
    cur_req = "R4";
    put_desc(32'h1000, 5, 32'h6000, 1, 1, 1, 12, 4'hE, 16'h0000);
    clear_counts();
    scan(1'b0);
    chk("R4 walk started", c_tdmd, 1);
    chk("R4 no tint", c_tint, 0);
    chk("R4 no error", c_elen + c_echain, 0);
    chk("R4 descriptor untouched", mem[dword(32'h1000, 5, 1)], 16'h8300);

    // R6: continuation with no open frame
    cur_req = "R6";
    put_desc(32'h1000, 5, 32'h6000, 1, 0, 1, 12, 4'hF, 16'h0000);
    clear_counts();
    scan(1'b0);
    chk("R6 err_chain", c_echain, 1);
    chk("R6 descriptor untouched", mem[dword(32'h1000, 5, 1)], 16'h8100);

    // R7: restart of an open frame
    cur_req = "R7";
    put_desc(32'h1000, 5, 32'h6000, 1, 1, 0, 12, 4'hF, 16'h0000);
    put_desc(32'h1000, 6, 32'h6100, 1, 1, 1, 14, 4'hF, 16'h0000);
    put_desc(32'h1000, 7, 0, 0, 0, 0, 12, 4'hF, 16'h0000);
    fill_buf(32'h6000, 12); fill_buf(32'h6100, 14);
    push_buf(32'h6000, 12, 1, 0); push_buf(32'h6100, 14, 1, 1);
    clear_counts();
    scan(1'b0);
    chk("R7 drop pulse", c_drop, 1);
    chk("R7 bytes", expq.size(), 0);
    chk("R7 tint", c_tint, 1);

    // R12: buffer across the SRAM top, walk started by poll tick
    cur_req = "R12";
    put_desc(32'h1000, 7, 32'h1FFFA, 1, 1, 1, 12, 4'hF, 16'h0000);
    fill_buf(32'h1FFFA, 12);
    push_buf(32'h1FFFA, 12, 1, 1);
    clear_counts();
    scan(1'b1);
    chk("R2 poll starts walk", c_tdmd, 1);
    chk("R12 wrapped bytes", expq.size(), 0);
    chk("R12 word1 writeback", mem[dword(32'h1000, 7, 1)], 16'h0301);

    // R11: two-entry ring fully owned, index wrapped back to 0
    cur_req = "R11";
    ring_base = 17'h3000;
    ring_log2 = 3'd1;
    put_desc(32'h3000, 0, 32'h7000, 1, 1, 1, 12, 4'hF, 16'h0000);
    put_desc(32'h3000, 1, 32'h7100, 1, 1, 1, 12, 4'hF, 16'h0000);
    fill_buf(32'h7000, 12); fill_buf(32'h7100, 12);
    push_buf(32'h7000, 12, 1, 1); push_buf(32'h7100, 12, 1, 1);
    clear_counts();
    scan(1'b0);
    chk("R11 ring_full", c_full, 1);
    chk("R11 two frames", c_tint, 2);
    chk("R11 bytes", expq.size(), 0);
    clear_counts();
    scan(1'b0);
    chk("R11 returned entries skipped", c_tint, 0);
    chk("R11 no lap warning", c_full, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule